// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block sits between a processor-side request port and an asynchronous DRAM array. Each request carries a full word address, a write flag and write data. The controller splits the address into row and column halves. It presents them one after the other on a narrow shared address bus and frames them with active-low row and column strobes. It also drives the write-enable and output-enable lines and captures the read word. A read result is returned on the request side as a one-cycle valid pulse.

A free-running interval timer raises a refresh request every `REF_INT` clock cycles. A row counter selects which row that refresh cycle strobes. A refresh that is pending is served before any new request. It never cuts into an access that has already started. A two-bit status output tells the rest of the system whether the controller is idle, running an access or refreshing.

Top module: `dram_ctrl`

## Requirements
- R1: While `rst_n` is low, all four DRAM strobes are high, `rsp_valid` is low and `status` is 0. Within three clock cycles of reset release, `req_ready` is high.
- R2: On an access, `dram_ma` carries the upper `ROW_W` address bits (the row) when `dram_ras_n` falls. It carries the lower `COL_W` bits (the column) when `dram_cas_n` falls.
- R3: `dram_cas_n` is low only while `dram_ras_n` is low and was already low in the previous cycle, so the row is always strobed before the column.
- R4: An access takes four cycles T1..T4 after the accepting edge. T1 has the row on the bus with RAS high, T2 drops RAS, and T3 and T4 hold CAS low. RAS falls two cycles after the accepting cycle and CAS falls three cycles after it.
- R5: During a write, `dram_we_n` is low only while CAS is low, `dram_oe_n` stays high, and `dram_dq_out` carries the accepted write data.
- R6: During a read, `dram_oe_n` is low only in T3 and T4 with `dram_we_n` high. `rsp_valid` is high for exactly one cycle, the cycle after T4, and `rsp_rdata` holds the word last written to that address.
- R7: Consecutive refresh row strobes, and the first one after reset, are never more than `REF_INT`+8 cycles apart.
- R8: A refresh is a RAS-only cycle with CAS high. It puts the refresh row counter on `dram_ma`. The counter advances by one after each refresh and wraps from 2^`ROW_W`-1 to 0.
- R9: A due refresh wins over a waiting request, and `req_ready` is low throughout a refresh. An access in progress always runs to T4 first.
- R10: `status` is 0 when idle, 1 during an access and 2 during a refresh. `req_ready` is high only when status is 0 and no refresh is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| dram_ma | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the array |
| dram_dq_in | input | DATA_W | Data from the array, high-impedance unless enabled |
| status | output | 2 | 0 idle, 1 access, 2 refresh |

## Verification
The hardest case to reach is a refresh that falls due on the same edge that accepts a request. The refresh must then wait out the whole access, which puts the gap between refresh strobes at its largest. The bench keeps a dense stream of back-to-back mixed reads and writes running across many refresh intervals, so the timer expiry lands on every phase of an access. At each refresh strobe it checks the gap bound and the row order. A long idle stretch then shows refresh running on its own. The behavioural array records every row strobe, so any missed row shows up at the end.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACC1, ST_ACC2, ST_ACC3, ST_ACC4,
    ST_REF1, ST_REF2, ST_REF3, ST_REF4
  } seq_state_t;

  localparam logic [1:0] STAT_IDLE    = 2'd0;
  localparam logic [1:0] STAT_ACCESS  = 2'd1;
  localparam logic [1:0] STAT_REFRESH = 2'd2;
endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q   <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_n_out <= stage_q;
    end
  end
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int ROW_W   = 3,
  parameter int REF_INT = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_due,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CNT_W = (REF_INT > 2) ? $clog2(REF_INT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_INT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             due_q, due_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    due_d = wrap | (due_q & ~ref_done);
    row_d = row_q;
    if (ref_done) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
      row_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
      row_q <= row_d;
    end
  end

  assign ref_due = due_q;
  assign ref_row = row_q;
endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  parameter int MA_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_wr,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_due,
  input  logic [ROW_W-1:0]       ref_row,
  output logic                   ref_done,
  output logic [MA_W-1:0]        ma,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [DATA_W-1:0]      dq_out,
  input  logic [DATA_W-1:0]      dq_in,
  output logic [1:0]             status
);
  localparam int AW = ROW_W + COL_W;

  seq_state_t        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              accept, capture;
  logic [MA_W-1:0]   row_ma, col_ma, ref_ma;

  assign row_ma = MA_W'(addr_q[AW-1:COL_W]);
  assign col_ma = MA_W'(addr_q[COL_W-1:0]);
  assign ref_ma = MA_W'(ref_row);

  assign req_ready = (state_q == ST_IDLE) && !ref_due;
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_ACC4) && !wr_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    wr_d     = wr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    rvalid_d = capture;
    if (capture) rdata_d = dq_in;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due) begin
          state_d = ST_REF1;
        end else if (accept) begin
          state_d = ST_ACC1;
          addr_d  = req_addr;
          wr_d    = req_wr;
          wdata_d = req_wdata;
        end
      end
      ST_ACC1: state_d = ST_ACC2;
      ST_ACC2: state_d = ST_ACC3;
      ST_ACC3: state_d = ST_ACC4;
      ST_ACC4: state_d = ST_IDLE;
      ST_REF1: state_d = ST_REF2;
      ST_REF2: state_d = ST_REF3;
      ST_REF3: state_d = ST_REF4;
      ST_REF4: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobe decode from the registered phase
  always_comb begin
    ma       = '0;
    ras_n    = 1'b1;
    cas_n    = 1'b1;
    we_n     = 1'b1;
    oe_n     = 1'b1;
    ref_done = 1'b0;
    status   = STAT_IDLE;
    unique case (state_q)
      ST_ACC1: begin ma = row_ma; status = STAT_ACCESS; end
      ST_ACC2: begin ma = row_ma; ras_n = 1'b0; status = STAT_ACCESS; end
      ST_ACC3, ST_ACC4: begin
        ma     = col_ma;
        ras_n  = 1'b0;
        cas_n  = 1'b0;
        we_n   = ~wr_q;
        oe_n   = wr_q;
        status = STAT_ACCESS;
      end
      ST_REF1: begin ma = ref_ma; status = STAT_REFRESH; end
      ST_REF2, ST_REF3: begin ma = ref_ma; ras_n = 1'b0; status = STAT_REFRESH; end
      ST_REF4: begin ma = ref_ma; ref_done = 1'b1; status = STAT_REFRESH; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      wr_q     <= wr_d;
      wdata_q  <= wdata_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign dq_out    = wdata_q;
  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int REF_INT = 40,
  localparam int AW     = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [MA_W-1:0]   dram_ma,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic [1:0]        status
);
  logic             rst_n_int;
  logic             ref_due, ref_done;
  logic [ROW_W-1:0] ref_row;

  dram_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_int)
  );

  dram_refresh_timer #(.ROW_W(ROW_W), .REF_INT(REF_INT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .ref_done(ref_done),
    .ref_due (ref_due),
    .ref_row (ref_row)
  );

  dram_access_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MA_W(MA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .ref_due  (ref_due),
    .ref_row  (ref_row),
    .ref_done (ref_done),
    .ma       (dram_ma),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_out   (dram_dq_out),
    .dq_in    (dram_dq_in),
    .status   (status)
  );
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int REF_INT = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [1:0] status
);
  localparam int GAP_MAX = REF_INT + 8;
  localparam int GW      = $clog2(GAP_MAX + 2) + 1;

  logic          ras_prev;
  logic [GW-1:0] gap_cnt;
  logic          ref_strobe;

  assign ref_strobe = (status == 2'd2) && !ras_n && ras_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      gap_cnt  <= '0;
    end else begin
      ras_prev <= ras_n;
      if (ref_strobe) gap_cnt <= '0;
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (!ras_n && !$past(ras_n)));                        // R3
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cas_n && oe_n));                                  // R5
  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_n && we_n));                                  // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                    // R6
  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GW'(GAP_MAX));                                     // R7
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> cas_n);                                  // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (status == 2'd0));                              // R10
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3);                                              // R10
endmodule

bind dram_ctrl dram_ctrl_chk #(.REF_INT(REF_INT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .we_n     (dram_we_n),
  .oe_n     (dram_oe_n),
  .status   (status)
);

// File: tb/sim_dram_ctrl.sv
`timescale 1ns/1ps
module sim_dram_ctrl;
  localparam int ROW_W   = 3;
  localparam int COL_W   = 3;
  localparam int DATA_W  = 8;
  localparam int REF_INT = 40;
  localparam int AW      = ROW_W + COL_W;
  localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS    = 1 << ROW_W;
  localparam int WORDS   = 1 << AW;
  localparam int GAP_MAX = REF_INT + 8;

  logic              clk, rst_n;
  logic              req_valid, req_ready, req_wr;
  logic [AW-1:0]     req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [MA_W-1:0]   dram_ma;
  logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [DATA_W-1:0] dram_dq_out, dram_dq_in;
  logic [1:0]        status;

  dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REF_INT(REF_INT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ma(dram_ma),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in),
    .status(status)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests, fails, cyc;
  bit done;

  // behavioural DRAM array
  logic [DATA_W-1:0] arr [WORDS];
  logic [ROW_W-1:0]  open_row;
  logic              m_ras_prev;
  always @(posedge clk) begin
    if (m_ras_prev && !dram_ras_n) open_row <= dram_ma[ROW_W-1:0];
    if (!dram_cas_n && !dram_we_n) arr[{open_row, dram_ma[COL_W-1:0]}] <= dram_dq_out;
    m_ras_prev <= dram_ras_n;
  end
  assign dram_dq_in = (!dram_oe_n && !dram_cas_n) ? arr[{open_row, dram_ma[COL_W-1:0]}] : 'z;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // scoreboard
  logic [DATA_W-1:0] shadow [WORDS];
  logic [DATA_W-1:0] expq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (wr) shadow[a] = d;
    else expq.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  bit               p_ras, p_cas, p_rsp;
  logic [AW-1:0]    acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  int               acc_cyc, last_ref, ref_cnt;
  logic [ROW_W-1:0] exp_ref_row;
  int               row_seen [ROWS];

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        if (status == 2'd2) begin
          chk(dram_ma == MA_W'(exp_ref_row), "R8 refresh row", int'(dram_ma), int'(exp_ref_row));
          chk(dram_cas_n, "R8 refresh CAS high", int'(dram_cas_n), 1);
          chk(cyc - last_ref <= GAP_MAX, "R7 refresh gap", cyc - last_ref, GAP_MAX);
          exp_ref_row = exp_ref_row + 1'b1;
          last_ref = cyc;
          ref_cnt++;
        end else begin
          chk(dram_ma == MA_W'(acc_addr[AW-1:COL_W]), "R2 row half", int'(dram_ma), int'(acc_addr[AW-1:COL_W]));
          chk(cyc == acc_cyc + 2, "R4 RAS timing", cyc - acc_cyc, 2);
        end
        row_seen[dram_ma[ROW_W-1:0]] = cyc;
      end
      if (p_cas && !dram_cas_n) begin
        chk(!p_ras && !dram_ras_n, "R3 RAS before CAS", int'(p_ras), 0);
        chk(dram_ma == MA_W'(acc_addr[COL_W-1:0]), "R2 column half", int'(dram_ma), int'(acc_addr[COL_W-1:0]));
        chk(cyc == acc_cyc + 3, "R4 CAS timing", cyc - acc_cyc, 3);
      end
      if (!dram_we_n) begin
        chk(!dram_cas_n && dram_oe_n, "R5 write strobes", int'({dram_cas_n, dram_oe_n}), 1);
        chk(dram_dq_out == acc_wdata, "R5 write data", int'(dram_dq_out), int'(acc_wdata));
      end
      if (!dram_oe_n) chk(dram_we_n && !dram_cas_n, "R6 read strobes", int'({dram_we_n, dram_cas_n}), 2);
      if (status == 2'd2) chk(!req_ready, "R9 ready low in refresh", int'(req_ready), 0);
      if (req_ready) chk(status == 2'd0, "R10 ready only idle", int'(status), 0);
      if (rsp_valid) begin
        chk(!p_rsp, "R6 single pulse", int'(p_rsp), 0);
        chk(cyc == acc_cyc + 5, "R6 rsp timing", cyc - acc_cyc, 5);
        if (expq.size() == 0) chk(1'b0, "R6 unexpected response", int'(rsp_rdata), -1);
        else begin
          logic [DATA_W-1:0] e;
          e = expq.pop_front();
          chk(rsp_rdata == e, "R6 read data", int'(rsp_rdata), int'(e));
        end
      end
      if (req_valid && req_ready) begin
        acc_addr = req_addr; acc_wdata = req_wdata; acc_cyc = cyc;
      end
    end
    p_ras = dram_ras_n; p_cas = dram_cas_n; p_rsp = rsp_valid;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    req_valid = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    p_ras = 1'b1; p_cas = 1'b1; p_rsp = 1'b0;
    last_ref = 0; ref_cnt = 0; exp_ref_row = '0; acc_cyc = 0;
    acc_addr = '0; acc_wdata = '0;
    for (int i = 0; i < ROWS; i++) row_seen[i] = 0;
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes in reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    chk(!rsp_valid && status == 2'd0, "R1 status in reset", int'(status), 0);
    #3 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && status == 2'd0, "R1 ready after reset", int'(req_ready), 1);

    // fill all words, then read back (back-to-back, spans refresh wraps)
    for (int a = 0; a < WORDS; a++) send(1'b1, AW'(a), DATA_W'(a * 37 + 11));
    for (int a = 0; a < WORDS; a++) send(1'b0, AW'(a), 'x);
    // corner addresses and data patterns
    send(1'b1, '0, '1);
    send(1'b1, '1, '0);
    send(1'b0, '0, 'x);
    send(1'b0, '1, 'x);
    send(1'b1, AW'(WORDS / 2), 8'hA5);
    send(1'b0, AW'(WORDS / 2), 'x);
    // idle: refresh runs alone
    repeat (REF_INT * ROWS + 20) @(negedge clk);
    // mixed stream, stepping addresses so timer expiry hits every phase
    for (int k = 0; k < 200; k++) begin
      if (k % 3 == 0) send(1'b1, AW'(k * 5), DATA_W'(k ^ 8'h5C));
      else send(1'b0, AW'(k * 7), 'x);
    end
    repeat (10) @(negedge clk);

    chk(expq.size() == 0, "R6 all reads answered", expq.size(), 0);
    chk(ref_cnt > ROWS, "R8 counter wrapped", ref_cnt, ROWS + 1);
    for (int r = 0; r < ROWS; r++)
      chk(cyc - row_seen[r] <= ROWS * GAP_MAX, "R7 every row refreshed", cyc - row_seen[r], ROWS * GAP_MAX);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule